// File: doc/BRIEF.md
# Threaded-Code Stack Processor Core

A compact 16-bit processor core meant to run threaded code. Program and data share one synchronous memory port. A code word whose two top bits are both set carries three 4-bit opcodes. Any other code word is a subroutine call to the address it holds, with no prefix opcode. Arithmetic is limited to one subtract that sets a borrow flag, so software builds addition from two subtractions. There is no conditional jump. A program branches by discarding the return address on top of the return stack, and the borrow flag decides whether that happens.

The programmer sees five 16-bit registers and the borrow flag. The registers are the program counter, the data stack pointer, the return stack pointer, the accumulator A and the address register X. Both stacks live in memory. Each stack is confined to a power-of-two region, and its pointer wraps inside that region. One interrupt request input is sampled between code words and enters a fixed vector as an implicit call.

Top module: `tc_core`

## Requirements
- R1: While `rst` is high, `mem_we` is 0 and `mem_addr` equals RESET_PC. After reset, the first word is fetched from RESET_PC, and both stack pointers hold their region base.
- R2: A word with bits [15:14] = 11 holds three opcodes in bits [11:8], [7:4] and [3:0], executed in that order, and PC then advances by one. Opcodes: 0 NOP, 1 RET, 2 SKB, 3 SUB, 4 PSH, 5 POP, 6 LDI, 7 LDD, 8 STI, 9 STD, 10 AX (X=A), 11 XA (A=X), 12 LIT, 13 RPOP (A=pop return stack), 14 RPSH (push A to return stack), 15 SWP (swap A and X).
- R3: Any other word is a call. It pushes PC+1 onto the return stack and sets PC to the word value.
- R4: SUB sets A to A-X modulo 2^16. It sets borrow to 1 exactly when A < X, comparing unsigned.
- R5: SKB pops and discards the top of the return stack when borrow is 1. It does nothing when borrow is 0.
- R6: RET loads PC from the top of the return stack. Any opcodes after it in the same word are not executed.
- R7: A push first decrements the pointer and then writes. A pop first reads and then increments the pointer. The low STK_LOG pointer bits wrap, so the pointer never leaves its 2^STK_LOG-word region. The first push after reset lands at base + 2^STK_LOG - 1.
- R8: LDI and STI access memory at X and then increment X. LDD and STD decrement X and then access memory at the new X.
- R9: LIT loads the next word after the current code word into A. That next word is skipped as code.
- R10: The interrupt request is sampled only before a code word is fetched. When it is taken, the address of that unexecuted word is pushed onto the return stack and execution jumps to IRQ_VEC. Further requests are ignored until a RET executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid the cycle after the address |

## Verification
The bench builds the core with 8-word stack regions (STK_LOG = 3), data stack base 0x0E00, return stack base 0x0F00 and interrupt vector 0x0100. With regions that small, nine pushes wrap the data stack pointer and a following pop wraps it back up. Every stack location fits in a 4K-word memory model, so the bench can inspect it directly. Subtract vectors cover both borrow outcomes, equal operands, zero and the sign boundary. Each vector is run through a nested call sequence, so the skip-on-borrow exit path can be seen in memory.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int SLOTS  = 3;
    localparam int GRP_W  = SLOTS * OP_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_RET  = 4'd1,
        OP_SKB  = 4'd2,
        OP_SUB  = 4'd3,
        OP_PSH  = 4'd4,
        OP_POP  = 4'd5,
        OP_LDI  = 4'd6,
        OP_LDD  = 4'd7,
        OP_STI  = 4'd8,
        OP_STD  = 4'd9,
        OP_AX   = 4'd10,
        OP_XA   = 4'd11,
        OP_LIT  = 4'd12,
        OP_RPOP = 4'd13,
        OP_RPSH = 4'd14,
        OP_SWP  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD
    } state_e;

    typedef enum logic {
        LD_A,
        LD_PC
    } ld_dst_e;

    typedef struct packed {
        state_e           st;
        word_t            pc;
        word_t            dsp;
        word_t            rsp;
        word_t            a;
        word_t            x;
        logic             brw;
        logic             imask;
        logic [1:0]       slot;
        logic [GRP_W-1:0] grp;
        ld_dst_e          dst;
    } core_s;
endpackage

// File: rtl/tc_wrap_ptr.sv
module tc_wrap_ptr
    import tc_pkg::*;
#(
    parameter int LOG = 5
) (
    input  word_t ptr,
    output word_t dec,
    output word_t inc
);
    logic [LOG-1:0] off;

    always_comb begin
        off = ptr[LOG-1:0];
        dec = {ptr[WORD_W-1:LOG], LOG'(off - 1'b1)};
        inc = {ptr[WORD_W-1:LOG], LOG'(off + 1'b1)};
    end
endmodule

// File: rtl/tc_sub.sv
module tc_sub
    import tc_pkg::*;
(
    input  word_t lhs,
    input  word_t rhs,
    output word_t diff,
    output logic  borrow
);
    always_comb begin
        {borrow, diff} = {1'b0, lhs} - {1'b0, rhs};
    end
endmodule

// File: rtl/tc_slot_dec.sv
module tc_slot_dec
    import tc_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    input  logic [1:0]       slot,
    output op_e              op
);
    logic [OP_W-1:0] field [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_field
        assign field[i] = grp[(SLOTS-1-i)*OP_W +: OP_W];
    end

    always_comb begin
        op = OP_NOP;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot == 2'(i)) op = op_e'(field[i]);
        end
    end
endmodule

// File: rtl/tc_core.sv
module tc_core
    import tc_pkg::*;
#(
    parameter word_t RESET_PC = 16'h0000,
    parameter word_t DS_BASE  = 16'hF000,
    parameter word_t RS_BASE  = 16'hF800,
    parameter int    STK_LOG  = 5,
    parameter word_t IRQ_VEC  = 16'h0040
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    input  logic [15:0] mem_rdata
);
    localparam logic [1:0] PACK_TAG  = 2'b11;
    localparam logic [1:0] LAST_SLOT = 2'(SLOTS - 1);
    localparam word_t      ONE       = word_t'(1);
    localparam core_s CORE_RST = '{
        st: ST_FETCH, pc: RESET_PC, dsp: DS_BASE, rsp: RS_BASE,
        a: '0, x: '0, brw: 1'b0, imask: 1'b0, slot: '0, grp: '0, dst: LD_A
    };

    core_s core_d, core_q;
    word_t ds_dec, ds_inc, rs_dec, rs_inc;
    word_t sub_diff;
    logic  sub_brw;
    op_e   cur_op;
    logic  step;
    logic  word_packed;

    tc_wrap_ptr #(.LOG(STK_LOG)) u_dsp (.ptr(core_q.dsp), .dec(ds_dec), .inc(ds_inc));
    tc_wrap_ptr #(.LOG(STK_LOG)) u_rsp (.ptr(core_q.rsp), .dec(rs_dec), .inc(rs_inc));
    tc_sub u_sub (.lhs(core_q.a), .rhs(core_q.x), .diff(sub_diff), .borrow(sub_brw));
    tc_slot_dec u_dec (.grp(core_q.grp), .slot(core_q.slot), .op(cur_op));

    assign word_packed = (mem_rdata[WORD_W-1 -: 2] == PACK_TAG);

    always_comb begin
        core_d    = core_q;
        mem_addr  = core_q.pc;
        mem_wdata = core_q.a;
        mem_we    = 1'b0;
        step      = 1'b0;
        unique case (core_q.st)
            ST_FETCH: begin
                if (irq && !core_q.imask) begin
                    mem_addr     = rs_dec;
                    mem_wdata    = core_q.pc;
                    mem_we       = 1'b1;
                    core_d.rsp   = rs_dec;
                    core_d.pc    = IRQ_VEC;
                    core_d.imask = 1'b1;
                end else begin
                    core_d.st = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (word_packed) begin
                    core_d.grp  = mem_rdata[GRP_W-1:0];
                    core_d.slot = '0;
                    core_d.st   = ST_EXEC;
                end else begin
                    mem_addr   = rs_dec;
                    mem_wdata  = core_q.pc + ONE;
                    mem_we     = 1'b1;
                    core_d.rsp = rs_dec;
                    core_d.pc  = mem_rdata;
                    core_d.st  = ST_FETCH;
                end
            end
            ST_EXEC: begin
                unique case (cur_op)
                    OP_NOP: step = 1'b1;
                    OP_RET: begin
                        mem_addr   = core_q.rsp;
                        core_d.rsp = rs_inc;
                        core_d.dst = LD_PC;
                        core_d.st  = ST_LOAD;
                    end
                    OP_SKB: begin
                        if (core_q.brw) core_d.rsp = rs_inc;
                        step = 1'b1;
                    end
                    OP_SUB: begin
                        core_d.a   = sub_diff;
                        core_d.brw = sub_brw;
                        step       = 1'b1;
                    end
                    OP_PSH: begin
                        mem_addr   = ds_dec;
                        mem_we     = 1'b1;
                        core_d.dsp = ds_dec;
                        step       = 1'b1;
                    end
                    OP_POP: begin
                        mem_addr   = core_q.dsp;
                        core_d.dsp = ds_inc;
                        core_d.dst = LD_A;
                        core_d.st  = ST_LOAD;
                    end
                    OP_LDI: begin
                        mem_addr   = core_q.x;
                        core_d.x   = core_q.x + ONE;
                        core_d.dst = LD_A;
                        core_d.st  = ST_LOAD;
                    end
                    OP_LDD: begin
                        mem_addr   = core_q.x - ONE;
                        core_d.x   = core_q.x - ONE;
                        core_d.dst = LD_A;
                        core_d.st  = ST_LOAD;
                    end
                    OP_STI: begin
                        mem_addr = core_q.x;
                        mem_we   = 1'b1;
                        core_d.x = core_q.x + ONE;
                        step     = 1'b1;
                    end
                    OP_STD: begin
                        mem_addr = core_q.x - ONE;
                        mem_we   = 1'b1;
                        core_d.x = core_q.x - ONE;
                        step     = 1'b1;
                    end
                    OP_AX: begin
                        core_d.x = core_q.a;
                        step     = 1'b1;
                    end
                    OP_XA: begin
                        core_d.a = core_q.x;
                        step     = 1'b1;
                    end
                    OP_LIT: begin
                        mem_addr   = core_q.pc + ONE;
                        core_d.pc  = core_q.pc + ONE;
                        core_d.dst = LD_A;
                        core_d.st  = ST_LOAD;
                    end
                    OP_RPOP: begin
                        mem_addr   = core_q.rsp;
                        core_d.rsp = rs_inc;
                        core_d.dst = LD_A;
                        core_d.st  = ST_LOAD;
                    end
                    OP_RPSH: begin
                        mem_addr   = rs_dec;
                        mem_we     = 1'b1;
                        core_d.rsp = rs_dec;
                        step       = 1'b1;
                    end
                    OP_SWP: begin
                        core_d.a = core_q.x;
                        core_d.x = core_q.a;
                        step     = 1'b1;
                    end
                    default: step = 1'b1;
                endcase
            end
            ST_LOAD: begin
                if (core_q.dst == LD_PC) begin
                    core_d.pc    = mem_rdata;
                    core_d.imask = 1'b0;
                    core_d.st    = ST_FETCH;
                end else begin
                    core_d.a = mem_rdata;
                    step     = 1'b1;
                end
            end
            default: core_d.st = ST_FETCH;
        endcase

        if (step) begin
            if (core_q.slot == LAST_SLOT) begin
                core_d.pc = core_q.pc + ONE;
                core_d.st = ST_FETCH;
            end else begin
                core_d.slot = core_q.slot + 2'd1;
                core_d.st   = ST_EXEC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= CORE_RST;
        else     core_q <= core_d;
    end

    // R7
    stack_region_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.dsp[WORD_W-1:STK_LOG] == DS_BASE[WORD_W-1:STK_LOG]) &&
        (core_q.rsp[WORD_W-1:STK_LOG] == RS_BASE[WORD_W-1:STK_LOG]));

    // R3
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_DECODE && !word_packed) |=>
        (core_q.pc == $past(mem_rdata) && core_q.st == ST_FETCH));

    // R4
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_EXEC && cur_op == OP_SUB) |=>
        (core_q.brw == ($past(core_q.a) < $past(core_q.x))));

    // R6
    ret_ends_word_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_LOAD && core_q.dst == LD_PC) |=>
        (core_q.st == ST_FETCH && !core_q.imask));

    // R10
    irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_q.imask) |-> (core_q.pc == IRQ_VEC && $past(irq)));

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_EXEC) |-> (core_q.slot <= LAST_SLOT));
endmodule

// File: tb/tb_tc_core.sv
module tb_tc_core;
    localparam logic [15:0] DSB  = 16'h0E00;
    localparam logic [15:0] RSB  = 16'h0F00;
    localparam logic [15:0] VEC  = 16'h0100;
    localparam logic [15:0] DONE = 16'h0801;
    localparam logic [15:0] W_LAL = 16'hCCAC; // LIT, AX, LIT

    // {a, x, expected diff, expected borrow}
    localparam logic [63:0] SUBV [7] = '{
        64'h0005_0003_0002_0000,
        64'h0003_0005_FFFE_0001,
        64'h0000_0001_FFFF_0001,
        64'h0007_0007_0000_0000,
        64'h8000_0001_7FFF_0000,
        64'h0000_0000_0000_0000,
        64'h1234_FFFF_1235_0001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic mem_we;

    logic [15:0] ram [0:4095];
    logic tb_clr = 1'b0, tb_ld = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [15:0] tb_data = '0;
    logic mon_en = 1'b0;
    int   bad_push = 0, irq_push = 0;
    int   checks = 0, errors = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    tc_core #(.RESET_PC(16'h0000), .DS_BASE(DSB), .RS_BASE(RSB),
              .STK_LOG(3), .IRQ_VEC(VEC)) dut (
        .clk(clk), .rst(rst), .irq(irq), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata));

    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 4096; i++) ram[i] <= '0;
        end else if (tb_ld) begin
            ram[tb_addr] <= tb_data;
        end else if (mem_we) begin
            ram[mem_addr[11:0]] <= mem_wdata;
        end
        mem_rdata <= ram[mem_addr[11:0]];
    end

    always @(negedge clk) begin
        if (mon_en && !rst && mem_we && mem_addr[15:3] == RSB[15:3]) begin
            if (mem_wdata == 16'h0003) irq_push <= irq_push + 1;
            if (mem_wdata == 16'h0101 || mem_wdata == 16'h0102) bad_push <= bad_push + 1;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_ram();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); tb_ld = 1'b1; tb_addr = a[11:0]; tb_data = d;
        @(negedge clk); tb_ld = 1'b0;
    endtask

    task automatic put_done(input logic [15:0] p);
        poke(p, W_LAL); poke(p + 1, DONE); poke(p + 2, 16'hD0E0);
        poke(p + 3, 16'hC800); poke(p + 4, p + 4);
    endtask

    task automatic wait_write(input string tag, input logic [15:0] a, input int lim);
        int n = 0;
        while (!(mem_we && mem_addr == a) && n < lim) begin
            @(negedge clk); n++;
        end
        if (n >= lim) check({tag, " timeout"}, 16'h0000, 16'h0001);
    endtask

    task automatic run_prog(input string tag);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        wait_write(tag, DONE, 3000);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 we in reset", {15'd0, mem_we}, 16'h0000);
        check("R1 addr in reset", mem_addr, 16'h0000);

        // R4 R5 R3 R6 table walk
        for (int v = 0; v < 7; v++) begin
            logic [15:0] va, vx, vd, vb;
            {va, vx, vd, vb} = SUBV[v];
            clear_ram();
            poke(16'h000, W_LAL); poke(16'h001, vx); poke(16'h002, va);
            poke(16'h003, 16'hC340);
            poke(16'h004, 16'h0020);
            put_done(16'h005);
            poke(16'h010, 16'hC214);
            poke(16'h020, 16'h0010);
            poke(16'h021, W_LAL); poke(16'h022, 16'h0800); poke(16'h023, 16'h5A5A);
            poke(16'h024, 16'hC810);
            run_prog("R4 sub program");
            check($sformatf("R4 diff vec%0d", v), ram[12'hE07], vd);
            check($sformatf("R5 skip-on-borrow vec%0d", v), ram[12'h800],
                  (vb != 0) ? 16'h0000 : 16'h5A5A);
            check($sformatf("R6 ret drops slot vec%0d", v), ram[12'hE06], 16'h0000);
            if (v == 0) begin
                check("R3 outer return addr", ram[12'hF07], 16'h0005);
                check("R3 inner return addr", ram[12'hF06], 16'h0021);
            end
        end

        // R8 R9 R2 pointer modes
        clear_ram();
        poke(16'h000, W_LAL); poke(16'h001, 16'h0810); poke(16'h002, 16'h1111);
        poke(16'h003, 16'hC8B8);
        poke(16'h004, 16'hC79B);
        poke(16'h005, 16'hC464);
        poke(16'h006, 16'hC6B4);
        put_done(16'h007);
        run_prog("R8 pointer program");
        check("R8 STD pre-decrement", ram[12'h810], 16'h0811);
        check("R8 STI post-increment", ram[12'h811], 16'h0811);
        check("R2 slot order push", ram[12'hE07], 16'h0810);
        check("R8 LDI reads before inc", ram[12'hE06], 16'h0811);
        check("R9 LDI post-increment X", ram[12'hE05], 16'h0812);

        // R7 stack wrap
        clear_ram();
        poke(16'h000, W_LAL); poke(16'h001, 16'h0777); poke(16'h002, 16'h0001);
        poke(16'h003, 16'hC444);
        poke(16'h004, 16'hC444);
        poke(16'h005, 16'hC44B);
        poke(16'h006, 16'hC45A);
        poke(16'h007, 16'hC580);
        put_done(16'h008);
        run_prog("R7 wrap program");
        check("R7 ninth push wraps to top", ram[12'hE07], 16'h0777);
        check("R7 eighth push at base", ram[12'hE00], 16'h0001);
        check("R7 below region untouched", ram[12'hDFF], 16'h0000);
        check("R7 above region untouched", ram[12'hE08], 16'h0000);
        check("R7 pop wraps to base", ram[12'h777], 16'h0001);

        // R10 interrupt
        clear_ram();
        poke(16'h000, W_LAL); poke(16'h001, 16'h0830); poke(16'h002, 16'h4321);
        poke(16'h003, 16'h0003);
        poke(16'h100, 16'hC800); poke(16'h101, 16'hC000); poke(16'h102, 16'hC100);
        mon_en = 1'b1;
        @(negedge clk); rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 no entry while low", ram[12'h830], 16'h0000);
        irq = 1'b1;
        wait_write("R10 first entry", 16'h0830, 300);
        @(negedge clk);
        wait_write("R10 re-entry after RET", 16'h0831, 300);
        irq = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        mon_en = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10 first ISR store", ram[12'h830], 16'h4321);
        check("R10 re-entry store", ram[12'h831], 16'h4321);
        check("R10 no entry after drop", ram[12'h832], 16'h0000);
        check("R10 masked inside ISR", 16'(bad_push), 16'h0000);
        check("R10 pushed unexecuted word addr", {15'd0, irq_push > 0}, 16'h0001);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule